// File: doc/BRIEF.md
# Integer and Floating-Point Issue Interlock

This block is the issue and stall controller of a single-issue, in-order pipeline. Integer operations pass through one execute stage before writeback. Two-stage floating-point operations (the add class) pass through E1 and then E2. Fused multiply-add and multiply-subtract pass through a multiply stage (EM), an accumulate stage (EA) and then E2. Every path ends in a single shared writeback stage. The block models occupancy and register destinations only. Datapaths, register contents and exceptions live elsewhere.

Each cycle the block may accept one decoded descriptor: a class code, two source register numbers and a destination register number. The descriptor is held in a decode slot until it issues. The block raises `stall` to freeze fetch and decode. On the issue cycle it drives one operand-source select per source operand. It also reports which stages are occupied, so that surrounding logic can steer the datapaths.

The length of the wait depends on the floating-point class. A read-after-write dependency on an instruction that is still executing adds one more cycle. In that case the operand is picked off the producing stage instead of being read from the register file.

Top module: `ilk_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every stage valid bit, and `stall` is low in the cycle after reset.
- R2: The class code selects the path: 0 is integer (E then WB), 1 is the add class (E1, E2, WB) and 2 is fused multiply (EM, EA, E2, WB). An instruction spends exactly one cycle in each stage, and the first stage on its path is occupied in the cycle after issue.
- R3: With no dependency and no structural conflict, an add-class instruction waits one stall cycle in decode before it issues.
- R4: With no dependency, a fused multiply instruction waits two stall cycles in decode before it issues.
- R5: In the first cycle an instruction sits in decode, a dependency exists if either source number equals the destination of a valid instruction in E, E1, EM, EA or E2. A dependency adds one stall cycle: an integer instruction waits 1 cycle, an add-class instruction 2 and a fused multiply 3.
- R6: An integer instruction is not issued while E1 or EA is occupied, and an add-class instruction is not issued while EM is occupied. E2 and WB therefore never receive two instructions in the same cycle. An integer instruction is not held back by EM alone.
- R7: While `stall` is high, the decode slot keeps its instruction, no new descriptor is accepted, and E, E1 and EM are all empty in the following cycle. A descriptor is accepted only in a cycle with `stall` low.
- R8: On the issue cycle (decode valid, `stall` low), each operand select is 1 when the source matches a valid E2 destination, is otherwise 2 when it matches a valid WB destination, and is otherwise 0 (register file). In every other cycle both selects are 0.
- R9: Back-to-back integer instructions with no dependency issue in consecutive cycles without any stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A descriptor is presented |
| in_class | input | 2 | Class code: 0 integer, 1 add class, 2 fused multiply |
| in_src0 | input | REG_W | First source register number |
| in_src1 | input | REG_W | Second source register number |
| in_dst | input | REG_W | Destination register number |
| stall | output | 1 | Hold fetch and decode this cycle |
| d_valid | output | 1 | Decode slot occupied |
| ex_valid | output | 1 | Integer execute stage occupied |
| e1_valid | output | 1 | First add-class stage occupied |
| em_valid | output | 1 | Multiply stage occupied |
| ea_valid | output | 1 | Accumulate stage occupied |
| e2_valid | output | 1 | Final floating-point stage occupied |
| wb_valid | output | 1 | Writeback stage occupied |
| byp_sel0 | output | 2 | Operand source for source 0 (0 file, 1 E2, 2 WB) |
| byp_sel1 | output | 2 | Operand source for source 1 (0 file, 1 E2, 2 WB) |

## Verification
The properties assume that the upstream stage holds its descriptor steady while `stall` is high and presents only class codes 0 to 2. The driver therefore changes the inputs only after a cycle in which `stall` was low, and it draws every descriptor from those three classes. The properties also assume reset is applied from the first clock edge. The bench holds `rst` high from time zero and asserts it once more in the middle of a stalled fused multiply.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    typedef enum logic [1:0] {
        CLS_INT  = 2'd0,
        CLS_FADD = 2'd1,
        CLS_FMAC = 2'd2,
        CLS_RSVD = 2'd3
    } ilk_class_e;

    typedef enum logic [1:0] {
        BYP_RF = 2'd0,
        BYP_E2 = 2'd1,
        BYP_WB = 2'd2
    } ilk_byp_e;

    // base decode wait per class, before any dependency penalty
    localparam int FADD_WAIT = 1;
    localparam int FMAC_WAIT = 2;
    localparam int DEP_WAIT  = 1;

endpackage

// File: rtl/ilk_hazard.sv
module ilk_hazard
    import ilk_pkg::*;
#(
    parameter int REG_W = 4,
    parameter int NSRC  = 2,
    parameter int NPROD = 5,
    parameter int CNT_W = 2
) (
    input  ilk_class_e                     cls,
    input  logic [NSRC-1:0][REG_W-1:0]     src,
    input  logic [NPROD-1:0]               prod_v,
    input  logic [NPROD-1:0][REG_W-1:0]    prod_dst,
    input  logic                           e1_busy,
    input  logic                           em_busy,
    input  logic                           ea_busy,
    output logic [CNT_W-1:0]               need,
    output logic                           struct_hz
);
    localparam int NHIT = NSRC * NPROD;

    logic [NHIT-1:0] hit;
    logic            dep;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        for (genvar p = 0; p < NPROD; p++) begin : g_prod
            assign hit[s*NPROD + p] = prod_v[p] && (prod_dst[p] == src[s]);
        end
    end

    assign dep = |hit;

    always_comb begin
        unique case (cls)
            CLS_FADD: need = CNT_W'(FADD_WAIT);
            CLS_FMAC: need = CNT_W'(FMAC_WAIT);
            default:  need = '0;
        endcase
        if (dep) need = need + CNT_W'(DEP_WAIT);
    end

    // path collisions in E2 and WB
    always_comb begin
        unique case (cls)
            CLS_FADD: struct_hz = em_busy;
            CLS_FMAC: struct_hz = 1'b0;
            default:  struct_hz = e1_busy || ea_busy;
        endcase
    end

endmodule

// File: rtl/ilk_bypass.sv
module ilk_bypass
    import ilk_pkg::*;
#(
    parameter int REG_W = 4,
    parameter int NSRC  = 2
) (
    input  logic                       issue,
    input  logic [NSRC-1:0][REG_W-1:0] src,
    input  logic                       e2_v,
    input  logic [REG_W-1:0]           e2_dst,
    input  logic                       wb_v,
    input  logic [REG_W-1:0]           wb_dst,
    output logic [NSRC-1:0][1:0]       sel
);
    for (genvar s = 0; s < NSRC; s++) begin : g_sel
        always_comb begin
            if (!issue)
                sel[s] = BYP_RF;
            else if (e2_v && e2_dst == src[s])
                sel[s] = BYP_E2;
            else if (wb_v && wb_dst == src[s])
                sel[s] = BYP_WB;
            else
                sel[s] = BYP_RF;
        end
    end

endmodule

// File: rtl/ilk_ctrl.sv
module ilk_ctrl
    import ilk_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_class,
    input  logic [REG_W-1:0] in_src0,
    input  logic [REG_W-1:0] in_src1,
    input  logic [REG_W-1:0] in_dst,
    output logic             stall,
    output logic             d_valid,
    output logic             ex_valid,
    output logic             e1_valid,
    output logic             em_valid,
    output logic             ea_valid,
    output logic             e2_valid,
    output logic             wb_valid,
    output logic [1:0]       byp_sel0,
    output logic [1:0]       byp_sel1
);
    localparam int NSRC     = 2;
    localparam int NPROD    = 5;
    localparam int MAX_WAIT = FMAC_WAIT + DEP_WAIT;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    typedef struct packed {
        logic             v;
        logic [REG_W-1:0] dst;
    } stage_t;

    typedef struct packed {
        stage_t                     d;
        ilk_class_e                 d_cls;
        logic [NSRC-1:0][REG_W-1:0] d_src;
        logic                       d_new;
        logic [CNT_W-1:0]           cnt;
        stage_t                     ex;
        stage_t                     e1;
        stage_t                     em;
        stage_t                     ea;
        stage_t                     e2;
        stage_t                     wb;
    } state_t;

    state_t s_d, s_q;

    logic [CNT_W-1:0]            need;
    logic                        struct_hz;
    logic [CNT_W-1:0]            wait_now;
    logic                        stall_w;
    logic                        issue;
    logic [NPROD-1:0]            prod_v;
    logic [NPROD-1:0][REG_W-1:0] prod_dst;
    logic [NSRC-1:0][1:0]        sel;

    assign prod_v   = {s_q.e2.v,   s_q.ea.v,   s_q.em.v,   s_q.e1.v,   s_q.ex.v};
    assign prod_dst = {s_q.e2.dst, s_q.ea.dst, s_q.em.dst, s_q.e1.dst, s_q.ex.dst};

    ilk_hazard #(
        .REG_W (REG_W),
        .NSRC  (NSRC),
        .NPROD (NPROD),
        .CNT_W (CNT_W)
    ) u_hazard (
        .cls       (s_q.d_cls),
        .src       (s_q.d_src),
        .prod_v    (prod_v),
        .prod_dst  (prod_dst),
        .e1_busy   (s_q.e1.v),
        .em_busy   (s_q.em.v),
        .ea_busy   (s_q.ea.v),
        .need      (need),
        .struct_hz (struct_hz)
    );

    // wait is taken from the hazard check once, on the first decode cycle
    assign wait_now = s_q.d_new ? need : s_q.cnt;
    assign stall_w  = s_q.d.v && ((wait_now != '0) || struct_hz);
    assign issue    = s_q.d.v && !stall_w;

    ilk_bypass #(
        .REG_W (REG_W),
        .NSRC  (NSRC)
    ) u_bypass (
        .issue  (issue),
        .src    (s_q.d_src),
        .e2_v   (s_q.e2.v),
        .e2_dst (s_q.e2.dst),
        .wb_v   (s_q.wb.v),
        .wb_dst (s_q.wb.dst),
        .sel    (sel)
    );

    always_comb begin
        s_d = s_q;

        if (stall_w) begin
            s_d.d_new = 1'b0;
            s_d.cnt   = (wait_now != '0) ? wait_now - CNT_W'(1) : '0;
        end else begin
            s_d.d.v   = in_valid;
            s_d.d.dst = in_dst;
            s_d.d_cls = ilk_class_e'(in_class);
            s_d.d_src = {in_src1, in_src0};
            s_d.d_new = in_valid;
            s_d.cnt   = '0;
        end

        s_d.ex.v   = issue && (s_q.d_cls != CLS_FADD) && (s_q.d_cls != CLS_FMAC);
        s_d.ex.dst = s_q.d.dst;
        s_d.e1.v   = issue && (s_q.d_cls == CLS_FADD);
        s_d.e1.dst = s_q.d.dst;
        s_d.em.v   = issue && (s_q.d_cls == CLS_FMAC);
        s_d.em.dst = s_q.d.dst;
        s_d.ea     = s_q.em;
        s_d.e2     = s_q.e1.v ? s_q.e1 : s_q.ea;
        s_d.wb     = s_q.ex.v ? s_q.ex : s_q.e2;

        if (rst) s_d = '0;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign stall    = stall_w;
    assign d_valid  = s_q.d.v;
    assign ex_valid = s_q.ex.v;
    assign e1_valid = s_q.e1.v;
    assign em_valid = s_q.em.v;
    assign ea_valid = s_q.ea.v;
    assign e2_valid = s_q.e2.v;
    assign wb_valid = s_q.wb.v;
    assign byp_sel0 = sel[0];
    assign byp_sel1 = sel[1];

endmodule

// File: rtl/ilk_ctrl_chk.sv
module ilk_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       stall,
    input logic       d_valid,
    input logic       ex_valid,
    input logic       e1_valid,
    input logic       em_valid,
    input logic       ea_valid,
    input logic       e2_valid,
    input logic       wb_valid,
    input logic [1:0] byp_sel0,
    input logic [1:0] byp_sel1
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> !(ex_valid || e1_valid || em_valid || ea_valid || e2_valid || wb_valid || stall || d_valid));

    a_r2_em_to_ea: assert property (@(posedge clk) disable iff (rst)
        em_valid |=> ea_valid);

    a_r2_ea_to_e2: assert property (@(posedge clk) disable iff (rst)
        ea_valid |=> e2_valid);

    a_r2_e1_to_e2: assert property (@(posedge clk) disable iff (rst)
        e1_valid |=> e2_valid);

    a_r2_to_wb: assert property (@(posedge clk) disable iff (rst)
        (ex_valid || e2_valid) |=> wb_valid);

    a_r6_single_e2_entry: assert property (@(posedge clk) disable iff (rst)
        !(e1_valid && ea_valid));

    a_r6_single_wb_entry: assert property (@(posedge clk) disable iff (rst)
        !(ex_valid && e2_valid));

    a_r7_stall_needs_decode: assert property (@(posedge clk) disable iff (rst)
        stall |-> d_valid);

    a_r7_decode_held: assert property (@(posedge clk) disable iff (rst)
        stall |=> d_valid);

    a_r7_bubble: assert property (@(posedge clk) disable iff (rst)
        stall |=> !(ex_valid || e1_valid || em_valid));

    a_r8_select_idle: assert property (@(posedge clk) disable iff (rst)
        (!d_valid || stall) |-> (byp_sel0 == 2'd0 && byp_sel1 == 2'd0));

    a_r8_select_legal: assert property (@(posedge clk) disable iff (rst)
        (byp_sel0 != 2'd3) && (byp_sel1 != 2'd3));

endmodule

bind ilk_ctrl ilk_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .stall    (stall),
    .d_valid  (d_valid),
    .ex_valid (ex_valid),
    .e1_valid (e1_valid),
    .em_valid (em_valid),
    .ea_valid (ea_valid),
    .e2_valid (e2_valid),
    .wb_valid (wb_valid),
    .byp_sel0 (byp_sel0),
    .byp_sel1 (byp_sel1)
);

// File: tb/sim_ilk_ctrl.sv
module sim_ilk_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [1:0] in_class = '0;
    logic [3:0] in_src0 = '0;
    logic [3:0] in_src1 = '0;
    logic [3:0] in_dst = '0;
    logic       stall, d_valid, ex_valid, e1_valid, em_valid, ea_valid, e2_valid, wb_valid;
    logic [1:0] byp_sel0, byp_sel1;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        int    cls;
        int    stalls;
        int    s0;
        int    s1;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    ilk_ctrl #(.REG_W(4)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
        .in_src0(in_src0), .in_src1(in_src1), .in_dst(in_dst),
        .stall(stall), .d_valid(d_valid), .ex_valid(ex_valid), .e1_valid(e1_valid),
        .em_valid(em_valid), .ea_valid(ea_valid), .e2_valid(e2_valid), .wb_valid(wb_valid),
        .byp_sel0(byp_sel0), .byp_sel1(byp_sel1)
    );

    task automatic chk(input int act, input int exp, input string req);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: records the expected issue, then presents the descriptor until accepted
    task automatic send(input int cls, input int s0, input int s1, input int dst,
                        input int est, input int es0, input int es1, input string tag);
        exp_q.push_back('{cls, est, es0, es1, tag});
        @(negedge clk);
        in_valid = 1'b1;
        in_class = 2'(cls);
        in_src0  = 4'(s0);
        in_src1  = 4'(s1);
        in_dst   = 4'(dst);
        while (stall) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: counts decode stalls per instruction and compares on its issue cycle
    int scnt = 0;
    bit pend = 1'b0;
    int pend_cls = 0;
    bit prev_st = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            exp_q.delete();
            scnt    = 0;
            pend    = 1'b0;
            prev_st = 1'b0;
        end else begin
            if (prev_st)
                chk(int'({em_valid, e1_valid, ex_valid}), 0, "R7 bubble after stall");
            if (pend)
                chk(int'({em_valid, e1_valid, ex_valid}), 1 << pend_cls, "R2 entry stage");
            pend = 1'b0;
            if (d_valid && stall) begin
                scnt++;
            end else if (d_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1, 0, "R7 unexpected issue");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(scnt, e.stalls, {e.tag, " stall cycles"});
                    chk(int'(byp_sel0), e.s0, "R8 select source 0");
                    chk(int'(byp_sel1), e.s1, "R8 select source 1");
                    pend     = 1'b1;
                    pend_cls = e.cls;
                end
                scnt = 0;
            end
            prev_st = stall;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(int'({d_valid, ex_valid, e1_valid, em_valid, ea_valid, e2_valid, wb_valid}), 0, "R1 valids after reset");
        chk(int'(stall), 0, "R1 stall after reset");

        // alternating integer and add class, no dependency
        send(0, 2, 3, 1, 0, 0, 0, "R9");
        send(1, 5, 6, 4, 1, 0, 0, "R3");
        send(0, 8, 9, 7, 1, 0, 0, "R6 int behind E1");
        send(1, 11, 12, 10, 1, 0, 0, "R3");
        idle(10);

        // alternating integer and add class, with dependency
        send(0, 1, 2, 0, 0, 0, 0, "R9");
        send(1, 0, 4, 2, 2, 0, 0, "R5 fadd dep");
        send(0, 2, 6, 5, 1, 1, 0, "R5 int dep");
        send(1, 5, 9, 7, 2, 0, 0, "R5 fadd dep");
        idle(10);

        // integer and fused multiply, no dependency
        send(0, 1, 1, 0, 0, 0, 0, "R9");
        send(2, 3, 4, 2, 2, 0, 0, "R4");
        send(0, 6, 6, 5, 0, 0, 0, "R6 int beside EM");
        send(2, 8, 9, 7, 2, 0, 0, "R4");
        idle(10);

        // integer and fused multiply, with dependency
        send(0, 1, 1, 0, 0, 0, 0, "R9");
        send(2, 0, 4, 0, 3, 0, 0, "R5 fmac dep");
        send(0, 0, 6, 5, 2, 1, 0, "R5 int dep on EM");
        send(2, 5, 9, 7, 3, 0, 0, "R5 fmac dep");
        idle(10);

        // integer chain: writeback bypass, then back-to-back issue
        send(0, 1, 2, 3, 0, 0, 0, "R9");
        send(0, 3, 3, 4, 1, 2, 2, "R5 int dep");
        send(0, 5, 6, 8, 0, 0, 0, "R9");
        send(0, 9, 10, 11, 0, 0, 0, "R9");
        idle(10);
        chk(exp_q.size(), 0, "R7 all instructions issued");

        // reset while a fused multiply is held in decode
        @(negedge clk);
        in_valid = 1'b1;
        in_class = 2'd2;
        in_src0  = 4'd1;
        in_src1  = 4'd2;
        in_dst   = 4'd3;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(int'(stall), 1, "R4 held fmac stalls");
        chk(int'(d_valid), 1, "R7 decode occupied");
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(int'({d_valid, ex_valid, e1_valid, em_valid, ea_valid, e2_valid, wb_valid}), 0, "R1 mid-run reset valids");
        chk(int'(stall), 0, "R1 mid-run reset stall");
        @(negedge clk);
        chk(int'({em_valid, e1_valid, ex_valid}), 0, "R1 nothing issued after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule